// File: doc/BRIEF.md
# USB Bus Activity Detector

This block watches the decoded line state of a full-speed USB bus and drives a single active-high flag, `bus_active`, that says whether packet traffic is present. A recovered-clock front end supplies a one-cycle `bit_stb` pulse once per bit time, together with the current raw line symbol (J, K, SE0) and a `bus_reset` indication. The flag rises when the synchronisation pattern that opens every packet is seen. It falls once the line has sat in idle J for a full run of bit times, or as soon as the bus is in reset.

The detector works on raw line symbols, not on NRZI-decoded data. A packet start is the symbol sequence K J K J K J K K on consecutive bit strobes. A counter of consecutive J strobes measures idle time. It restarts on any non-J symbol and stops at its limit. On cycles without a strobe the block ignores its line input, so it can share a fast system clock with the bit-recovery logic.

Top module: `usb_activity_monitor`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge) `bus_active` is 0, and it stays 0 until a packet start is seen.
- R2: Symbol encoding on `line_state` is SE0=2'b00, J=2'b01, K=2'b10, 2'b11 is treated as a non-J, non-K symbol. When the symbols K,J,K,J,K,J,K,K arrive on eight consecutive strobes, with `bus_reset` low on the last one, `bus_active` is 1 from the clock edge that ends the strobe cycle carrying the final K.
- R3: While `bus_active` is 1, a run of 31 or fewer consecutive J strobes leaves it at 1.
- R4: The strobe carrying the 32nd consecutive J (IDLE_LIMIT) clears `bus_active` at the clock edge that ends that cycle, unless a packet start completes on the same strobe.
- R5: Any K, SE0 or 2'b11 symbol on a strobe restarts the J run, so a full fresh run of 32 J strobes is needed after it to clear the flag.
- R6: `bus_reset` high in any cycle, strobed or not, makes `bus_active` 0 at the following edge, and a packet start completing while `bus_reset` is high does not set the flag.
- R7: In cycles with `bit_stb` low the value of `line_state` has no effect: it neither breaks nor builds a packet start, does not count as idle, and `bus_active` holds.
- R8: Symbol sequences that differ from the packet-start pattern in any position (for example K,J,K,J,K,J,K,J or a SE0 in place of the seventh symbol) do not set `bus_active`.
- R9: The idle counter saturates: after an arbitrarily long J run, a packet start still sets the flag, and 32 further J strobes clear it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle pulse per USB bit time |
| line_state | input | 2 | Raw line symbol: 00 SE0, 01 J, 10 K, 11 illegal |
| bus_reset | input | 1 | High while the bus is held in reset |
| bus_active | output | 1 | Active-high bus-activity flag |

## Verification
The bench targets the idle boundary: 31 J strobes must keep the flag and the 32nd must drop it. A counter off by one would clear the flag a bit early or late, and one that wraps instead of saturating would fail after long idles. Near-miss patterns and packet starts split by unstrobed cycles carrying junk symbols catch a matcher that samples every clock, or one that compares against the wrong position. Bus reset is pulsed in unstrobed cycles and across a complete packet start, which exposes a design that only clears on strobes or lets the start override reset.

// File: rtl/usb_act_pkg.sv
// Package: shared line-symbol type and the packet-start pattern generator.
// Assumes the front end presents one of four raw symbols per bit strobe.
package usb_act_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_t;

    // Symbol expected at position pos (0 = oldest) of a start pattern of length len:
    // alternating K/J beginning with K, ending with two K symbols.
    function automatic logic [1:0] start_symbol(input int pos, input int len);
        if (pos >= len - 2) begin
            return SYM_K;
        end
        return (pos % 2 == 0) ? SYM_K : SYM_J;
    endfunction

endpackage

// File: rtl/sync_hunter.sv
// sync_hunter: keeps the last SYNC_LEN-1 strobed symbols and flags, combinationally,
// the strobe whose symbol completes the packet-start pattern.
// Assumes bit_stb is a single-cycle pulse; unstrobed cycles leave history untouched.
module sync_hunter #(
    parameter int SYNC_LEN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic [1:0] line_state,
    output logic       start_hit
);
    import usb_act_pkg::*;

    localparam int HIST = SYNC_LEN - 1;

    // hist_q[k] holds the symbol seen k+1 strobes ago
    logic [HIST-1:0][1:0] hist_q;
    logic [HIST-1:0]      pos_ok;

    // History shift register, advanced on strobes only, reset to idle J
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= {HIST{SYM_J}};
        end else if (bit_stb) begin
            hist_q <= {hist_q[HIST-2:0], line_state};
        end
    end

    // Per-position comparison against the pattern
    for (genvar k = 0; k < HIST; k++) begin : g_cmp
        assign pos_ok[k] = (hist_q[k] == start_symbol(HIST - 1 - k, SYNC_LEN));
    end

    // Match when the current strobed symbol closes the pattern
    always_comb begin
        start_hit = bit_stb && (line_state == start_symbol(SYNC_LEN - 1, SYNC_LEN)) && (&pos_ok);
    end

endmodule

// File: rtl/idle_run_counter.sv
// idle_run_counter: counts consecutive strobed J symbols, saturating at IDLE_LIMIT,
// and raises idle_expire on any strobe after which the run has reached the limit.
// Assumes any non-J strobed symbol restarts the run.
module idle_run_counter #(
    parameter int IDLE_LIMIT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic [1:0] line_state,
    output logic       idle_expire
);
    import usb_act_pkg::*;

    localparam int            CW      = $clog2(IDLE_LIMIT + 1);
    localparam logic [CW-1:0] LIM     = CW'(IDLE_LIMIT);
    localparam logic [CW-1:0] LIM_M1  = CW'(IDLE_LIMIT - 1);

    logic [CW-1:0] run_q;
    logic          is_j;

    // Decode idle symbol
    always_comb begin
        is_j = (line_state == SYM_J);
    end

    // Run length register: increment on J, clear on anything else, hold at limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_stb) begin
            if (!is_j) begin
                run_q <= '0;
            end else if (run_q != LIM) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Expiry when this strobe brings (or keeps) the run at the limit
    always_comb begin
        idle_expire = bit_stb && is_j && (run_q >= LIM_M1);
    end

endmodule

// File: rtl/activity_flag_ctrl.sv
// activity_flag_ctrl: holds the activity flag. Priority: bus reset clears on any cycle,
// then a packet start sets, then idle expiry clears. Otherwise the flag holds.
// Assumes start_hit and idle_expire are only high in strobe cycles.
module activity_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic start_hit,
    input  logic idle_expire,
    output logic flag
);
    logic flag_q;

    // Flag register with fixed set/clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (bus_reset) begin
            flag_q <= 1'b0;
        end else if (start_hit) begin
            flag_q <= 1'b1;
        end else if (idle_expire) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/usb_activity_monitor.sv
// usb_activity_monitor: top of the bus-activity detector. Combines the packet-start
// hunter, the idle-run counter and the flag controller.
// Assumes line_state is valid whenever bit_stb is high.
module usb_activity_monitor #(
    parameter int SYNC_LEN   = 8,
    parameter int IDLE_LIMIT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic [1:0] line_state,
    input  logic       bus_reset,
    output logic       bus_active
);
    logic start_hit;
    logic idle_expire;

    sync_hunter #(.SYNC_LEN(SYNC_LEN)) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .line_state (line_state),
        .start_hit  (start_hit)
    );

    idle_run_counter #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .line_state  (line_state),
        .idle_expire (idle_expire)
    );

    activity_flag_ctrl u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset   (bus_reset),
        .start_hit   (start_hit),
        .idle_expire (idle_expire),
        .flag        (bus_active)
    );

endmodule

// File: rtl/usb_activity_monitor_chk.sv
// usb_activity_monitor_chk: temporal checks on the detector's ports, bound to the top.
// Keeps its own J-run count so the idle window is not unrolled.
module usb_activity_monitor_chk #(
    parameter int IDLE_LIMIT = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_stb,
    input logic [1:0] line_state,
    input logic       bus_reset,
    input logic       bus_active
);
    localparam int            CW  = $clog2(IDLE_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

    logic [CW-1:0] chk_run;

    // Independent count of consecutive strobed J symbols
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_run <= '0;
        end else if (bit_stb) begin
            if (line_state != 2'b01) begin
                chk_run <= '0;
            end else if (chk_run != LIM) begin
                chk_run <= chk_run + 1'b1;
            end
        end
    end

    // R6: bus reset forces the flag low at the next edge
    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_active);

    // R7: no strobe and no bus reset means the flag holds
    a_r7_hold_unstrobed: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !bus_reset) |=> $stable(bus_active));

    // R2: the flag only rises after a strobed K outside bus reset
    a_r2_rise_on_k: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_active) |-> $past(bit_stb && line_state == 2'b10 && !bus_reset));

    // R4: the flag only falls after a strobed J or a bus reset
    a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_active) |-> $past(bus_reset || (bit_stb && line_state == 2'b01)));

    // R3: a J run still short of the limit keeps the flag
    a_r3_short_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !bus_reset && bit_stb && line_state == 2'b01
         && chk_run < LIM - 1'b1) |=> bus_active);

    // R4: reaching the limit on a J strobe clears the flag
    a_r4_limit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && line_state == 2'b01 && chk_run >= LIM - 1'b1) |=> !bus_active);

endmodule

bind usb_activity_monitor usb_activity_monitor_chk #(.IDLE_LIMIT(IDLE_LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .line_state (line_state),
    .bus_reset  (bus_reset),
    .bus_active (bus_active)
);

// File: tb/tb_usb_activity_monitor.sv
module tb_usb_activity_monitor;

    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] J   = 2'b01;
    localparam logic [1:0] K   = 2'b10;
    localparam logic [1:0] SE1 = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic [1:0] line_state = J;
    logic       bus_reset = 1'b0;
    logic       bus_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [1:0] m_hist [0:6];   // m_hist[0] = newest previous symbol
    int         m_run = 0;
    bit         m_flag = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    usb_activity_monitor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .line_state (line_state),
        .bus_reset  (bus_reset),
        .bus_active (bus_active)
    );

    function automatic bit is_start(input logic [1:0] h [0:6], input logic [1:0] cur);
        // oldest..newest: K J K J K J K K
        return h[6] == K && h[5] == J && h[4] == K && h[3] == J &&
               h[2] == K && h[1] == J && h[0] == K && cur == K;
    endfunction

    task automatic check(input string tag, input bit exp);
        n_cmp++;
        if (bus_active !== exp) begin
            n_bad++;
            $display("FAIL %s: bus_active=%b expected=%b at %0t", tag, bus_active, exp, $time);
        end
    endtask

    // One clock: drive at negedge, update model, sample at next negedge
    task automatic step(input bit stb, input logic [1:0] ls, input bit rst, input string tag);
        bit hit;
        int run_n;
        bit_stb = stb; line_state = ls; bus_reset = rst;
        hit = stb && is_start(m_hist, ls);
        run_n = (ls == J) ? ((m_run < 32) ? m_run + 1 : 32) : 0;
        if (rst) m_flag = 1'b0;
        else if (hit) m_flag = 1'b1;
        else if (stb && run_n >= 32) m_flag = 1'b0;
        if (stb) begin
            for (int i = 6; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = ls;
            m_run = run_n;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, m_flag);
    endtask

    task automatic sym(input logic [1:0] ls, input string tag);
        step(1'b1, ls, 1'b0, tag);
    endtask

    task automatic send_start(input string tag);
        sym(K, tag); sym(J, tag); sym(K, tag); sym(J, tag);
        sym(K, tag); sym(J, tag); sym(K, tag); sym(K, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) sym(J, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bit_stb = 1'b0; bus_reset = 1'b0; line_state = J;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 7; i++) m_hist[i] = J;
        m_run = 0; m_flag = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0420);
        do_reset();
        @(negedge clk);
        check("R1 reset value", 1'b0);
        idle(10, "R1 idle after reset");
        sym(K, "R1"); sym(K, "R1");
        check("R1 no activity yet", 1'b0);

        // R2 basic packet start
        send_start("R2 start");
        check("R2 flag set", 1'b1);

        // R3 31 J then K keeps flag
        idle(31, "R3 short idle");
        check("R3 after 31 J", 1'b1);
        sym(K, "R3 K breaks run");
        check("R3 still high", 1'b1);

        // R4 exactly 32 J clears
        idle(31, "R4 idle");
        check("R4 at 31 J", 1'b1);
        sym(J, "R4 32nd J");
        check("R4 cleared at 32", 1'b0);

        // R5 SE0 and SE1 restart the run
        send_start("R5 start");
        idle(20, "R5 idle");
        sym(SE0, "R5 SE0");
        idle(31, "R5 idle");
        check("R5 SE0 restarted run", 1'b1);
        sym(SE1, "R5 SE1");
        idle(31, "R5 idle");
        check("R5 SE1 restarted run", 1'b1);
        sym(J, "R5 32nd");
        check("R5 cleared", 1'b0);

        // R6 bus reset in unstrobed cycle, and across a full start
        send_start("R6 start");
        step(1'b0, SE0, 1'b1, "R6 reset pulse");
        check("R6 cleared by reset", 1'b0);
        step(1'b1, K, 1'b1, "R6"); step(1'b1, J, 1'b1, "R6");
        step(1'b1, K, 1'b1, "R6"); step(1'b1, J, 1'b1, "R6");
        step(1'b1, K, 1'b1, "R6"); step(1'b1, J, 1'b1, "R6");
        step(1'b1, K, 1'b1, "R6"); step(1'b1, K, 1'b1, "R6");
        check("R6 start under reset ignored", 1'b0);

        // R7 junk in unstrobed cycles
        idle(40, "R7 idle");
        sym(K, "R7"); step(1'b0, SE0, 1'b0, "R7 gap"); sym(J, "R7");
        step(1'b0, K, 1'b0, "R7 gap"); sym(K, "R7"); sym(J, "R7");
        step(1'b0, J, 1'b0, "R7 gap"); sym(K, "R7"); sym(J, "R7");
        sym(K, "R7"); step(1'b0, SE1, 1'b0, "R7 gap"); sym(K, "R7");
        check("R7 start with gaps", 1'b1);
        for (int i = 0; i < 50; i++) step(1'b0, J, 1'b0, "R7 unstrobed J");
        check("R7 unstrobed J ignored", 1'b1);

        // R8 near misses
        idle(40, "R8 idle");
        sym(K, "R8"); sym(J, "R8"); sym(K, "R8"); sym(J, "R8");
        sym(K, "R8"); sym(J, "R8"); sym(K, "R8"); sym(J, "R8");
        check("R8 KJKJKJKJ", 1'b0);
        sym(K, "R8"); sym(J, "R8"); sym(K, "R8"); sym(J, "R8");
        sym(K, "R8"); sym(J, "R8"); sym(SE0, "R8"); sym(K, "R8");
        check("R8 SE0 in pattern", 1'b0);

        // R9 saturation over long idle
        idle(150, "R9 long idle");
        send_start("R9 start");
        check("R9 set after long idle", 1'b1);
        idle(32, "R9 idle");
        check("R9 cleared again", 1'b0);

        // Constrained random phase
        for (int it = 0; it < 2500; it++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 3) begin
                logic [1:0] pat [0:7];
                pat = '{K, J, K, J, K, J, K, K};
                for (int p = 0; p < 8; p++) begin
                    int g;
                    g = $urandom_range(0, 3);
                    for (int q = 0; q < g; q++)
                        step(1'b0, 2'($urandom_range(0, 3)), 1'b0, "R7 random gap");
                    sym(pat[p], "R2 random start");
                end
            end else if (sel < 6) begin
                idle($urandom_range(25, 40), "R3/R4 random idle");
            end else if (sel < 8) begin
                sym(2'($urandom_range(0, 3)), "R5/R8 random symbol");
            end else if (sel == 8) begin
                int n;
                n = $urandom_range(1, 4);
                for (int q = 0; q < n; q++)
                    step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'b1, "R6 random reset");
            end else begin
                step(1'b0, 2'($urandom_range(0, 3)), 1'b0, "R7 random unstrobed");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule